// File: doc/BRIEF.md
# Packet-Gating Stream FIFO with Error Drop

This block is a stream buffer placed between a packet producer and a consumer. Each incoming packet is held in local storage until its final word has arrived. The consumer never sees a packet that is still being written, so it receives only whole packets.

The input is a valid/ready stream that carries a data word, an end-of-packet flag and an error flag. The error flag is examined only on the final word. When that final word is flagged as errored, the whole packet is thrown away: the write position returns to where the packet started. The output is a registered valid/ready stream that carries data and the end-of-packet flag.

Storage holds `2**DEPTH_LOG2` words. The `flush` input empties the buffer within one cycle, and so does the synchronous reset.

Top module: `pkt_hold_fifo`

## Requirements
- R1: In the cycle after `rst` or `flush` is sampled high, `out_valid` is low, `in_ready` is high and any stored words are gone; a later packet comes out alone.
- R2: While a packet is only partly written, its words are not presented. If its final word is accepted at clock edge E, `out_valid` is still low after E and rises after E+1, provided the buffer was empty before.
- R3: Words leave in arrival order with their data unchanged. `out_last` is 1 on exactly the word that entered with `in_last` = 1 and is 0 on every other word.
- R4: When a complete packet is followed by a partial one, only the complete packet is presented. After its final word is read, `out_valid` stays low until the partial packet receives its final word.
- R5: A packet whose final word carries `in_err` = 1 is discarded entirely. The packets before it and after it come out unchanged and in order.
- R6: `in_err` on a word that is not the final one has no effect; that packet is delivered in full.
- R7: Starting from empty, a single packet of exactly `2**DEPTH_LOG2` words (64 by default) is accepted with `in_ready` high before every word. Right after its final word is accepted, `in_ready` is low. The whole packet is then read back intact.
- R8: A packet that fills storage without a final word stalls. `in_ready` stays low and `out_valid` stays low until `flush` or `rst`.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data` and `out_last` hold their values.
- R10: Short packets can be written back to back while earlier ones are being read under intermittent `out_ready`. No word is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous empty of all stored words, active high |
| in_data | input | DATA_W | Incoming data word |
| in_last | input | 1 | Marks the final word of a packet |
| in_err | input | 1 | Error mark, examined with the final word only |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Buffer can take a word |
| out_data | output | DATA_W | Outgoing data word |
| out_last | output | 1 | Marks the final word of the outgoing packet |
| out_valid | output | 1 | Outgoing word is present |
| out_ready | input | 1 | Consumer takes the outgoing word |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and `DEPTH_LOG2` = 6, which gives 64 words of storage. At that depth, a packet that exactly fills storage and an overlong packet that stalls without a final word can both be driven in under a hundred cycles, so both the full-capacity case and the stall case are exercised directly. A 32-bit word is wide enough to carry a unique running tag in every word, so any loss, duplication or reordering across dropped and kept packets shows up as a data mismatch.

// File: rtl/pkt_hold_pkg.sv
package pkt_hold_pkg;

   // What the write side does with its pointers in a given cycle.
   typedef enum logic [1:0] {
      WR_IDLE     = 2'd0,  // no word accepted
      WR_STEP     = 2'd1,  // body word accepted, only the open pointer moves
      WR_SEAL     = 2'd2,  // clean final word, packet becomes readable
      WR_DISCARD  = 2'd3   // errored final word, open pointer falls back
   } wr_action_e;

endpackage

// File: rtl/pkt_hold_wrctl.sv
module pkt_hold_wrctl
   import pkt_hold_pkg::*;
#(
   parameter int DEPTH_LOG2 = 6,
   localparam int PW    = DEPTH_LOG2 + 1,
   localparam int DEPTH = 1 << DEPTH_LOG2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  flush,
   input  logic                  in_valid,
   input  logic                  in_last,
   input  logic                  in_err,
   input  logic [PW-1:0]         rd_ptr,
   output logic                  in_ready,
   output logic                  wr_en,
   output logic [DEPTH_LOG2-1:0] wr_addr,
   output logic [PW-1:0]         open_ptr,
   output logic [PW-1:0]         seal_ptr
);

   logic [PW-1:0] open_q;
   logic [PW-1:0] seal_q;
   logic [PW-1:0] occupied;
   logic          accept;
   wr_action_e    action;

   // Occupancy counts unread words up to the open (uncommitted) pointer.
   assign occupied = open_q - rd_ptr;
   assign in_ready = (occupied != PW'(DEPTH));
   assign accept   = in_valid && in_ready;

   always_comb begin
      action = WR_IDLE;
      if (accept) begin
         if (!in_last)    action = WR_STEP;
         else if (in_err) action = WR_DISCARD;
         else             action = WR_SEAL;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         open_q <= '0;
         seal_q <= '0;
      end else begin
         unique case (action)
            WR_STEP:    open_q <= open_q + PW'(1);
            WR_SEAL: begin
               open_q <= open_q + PW'(1);
               seal_q <= open_q + PW'(1);
            end
            WR_DISCARD: open_q <= seal_q;
            default:    ;
         endcase
      end
   end

   assign wr_en    = accept;
   assign wr_addr  = open_q[DEPTH_LOG2-1:0];
   assign open_ptr = open_q;
   assign seal_ptr = seal_q;

endmodule

// File: rtl/pkt_hold_store.sv
module pkt_hold_store #(
   parameter int WORD_W     = 33,
   parameter int DEPTH_LOG2 = 6,
   localparam int DEPTH = 1 << DEPTH_LOG2
) (
   input  logic                  clk,
   input  logic                  wr_en,
   input  logic [DEPTH_LOG2-1:0] wr_addr,
   input  logic [WORD_W-1:0]     wr_word,
   input  logic [DEPTH_LOG2-1:0] rd_addr,
   output logic [WORD_W-1:0]     rd_word
);

   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_word;
   end

   assign rd_word = cells[rd_addr];

endmodule

// File: rtl/pkt_hold_rdstage.sv
module pkt_hold_rdstage #(
   parameter int DATA_W     = 32,
   parameter int DEPTH_LOG2 = 6,
   localparam int PW = DEPTH_LOG2 + 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  flush,
   input  logic [PW-1:0]         seal_ptr,
   input  logic [DATA_W:0]       rd_word,
   output logic [DEPTH_LOG2-1:0] rd_addr,
   output logic [PW-1:0]         rd_ptr,
   output logic [DATA_W-1:0]     out_data,
   output logic                  out_last,
   output logic                  out_valid,
   input  logic                  out_ready
);

   logic [PW-1:0]     rd_q;
   logic              vld_q;
   logic              last_q;
   logic [DATA_W-1:0] data_q;
   logic              sealed_avail;
   logic              load;

   // Only sealed words are visible to the read side.
   assign sealed_avail = (rd_q != seal_ptr);
   assign load         = sealed_avail && (!vld_q || out_ready);

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         rd_q   <= '0;
         vld_q  <= 1'b0;
         last_q <= 1'b0;
         data_q <= '0;
      end else if (load) begin
         rd_q   <= rd_q + PW'(1);
         vld_q  <= 1'b1;
         last_q <= rd_word[DATA_W];
         data_q <= rd_word[DATA_W-1:0];
      end else if (out_ready) begin
         vld_q  <= 1'b0;
      end
   end

   assign rd_addr   = rd_q[DEPTH_LOG2-1:0];
   assign rd_ptr    = rd_q;
   assign out_data  = data_q;
   assign out_last  = last_q;
   assign out_valid = vld_q;

endmodule

// File: rtl/pkt_hold_fifo.sv
module pkt_hold_fifo #(
   parameter int DATA_W     = 32,
   parameter int DEPTH_LOG2 = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              flush,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic              in_err,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              out_valid,
   input  logic              out_ready
);

   localparam int PW     = DEPTH_LOG2 + 1;
   localparam int WORD_W = DATA_W + 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pkt_hold_fifo: DATA_W must be at least 1");
      end
      if (DEPTH_LOG2 < 1 || DEPTH_LOG2 > 12) begin : g_bad_depth
         $error("pkt_hold_fifo: DEPTH_LOG2 must lie in 1..12");
      end
   endgenerate

   logic                  wr_en;
   logic [DEPTH_LOG2-1:0] wr_addr;
   logic [DEPTH_LOG2-1:0] rd_addr;
   logic [PW-1:0]         open_ptr;
   logic [PW-1:0]         seal_ptr;
   logic [PW-1:0]         rd_ptr;
   logic [WORD_W-1:0]     rd_word;

   pkt_hold_wrctl #(.DEPTH_LOG2(DEPTH_LOG2)) u_wrctl (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .in_valid (in_valid),
      .in_last  (in_last),
      .in_err   (in_err),
      .rd_ptr   (rd_ptr),
      .in_ready (in_ready),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .open_ptr (open_ptr),
      .seal_ptr (seal_ptr)
   );

   pkt_hold_store #(.WORD_W(WORD_W), .DEPTH_LOG2(DEPTH_LOG2)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_word ({in_last, in_data}),
      .rd_addr (rd_addr),
      .rd_word (rd_word)
   );

   pkt_hold_rdstage #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_rdstage (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush),
      .seal_ptr  (seal_ptr),
      .rd_word   (rd_word),
      .rd_addr   (rd_addr),
      .rd_ptr    (rd_ptr),
      .out_data  (out_data),
      .out_last  (out_last),
      .out_valid (out_valid),
      .out_ready (out_ready)
   );

endmodule

// File: rtl/pkt_hold_fifo_chk.sv
module pkt_hold_fifo_chk #(
   parameter int DATA_W     = 32,
   parameter int DEPTH_LOG2 = 6,
   localparam int PW    = DEPTH_LOG2 + 1,
   localparam int DEPTH = 1 << DEPTH_LOG2
) (
   input logic              clk,
   input logic              rst,
   input logic              flush,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_last,
   input logic              in_err,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              out_valid,
   input logic              out_ready,
   input logic [PW-1:0]     open_ptr,
   input logic [PW-1:0]     seal_ptr,
   input logic [PW-1:0]     rd_ptr
);

   logic [PW-1:0] open_used;
   logic [PW-1:0] seal_used;
   assign open_used = open_ptr - rd_ptr;
   assign seal_used = seal_ptr - rd_ptr;

   p_reset_empties_r1: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready));

   p_flush_empties_r1: assert property (@(posedge clk) disable iff (rst)
      flush |=> (!out_valid && in_ready));

   p_partial_hidden_r2: assert property (@(posedge clk) disable iff (rst)
      seal_used <= open_used);

   p_err_discard_r5: assert property (@(posedge clk) disable iff (rst || flush)
      (in_valid && in_ready && in_last && in_err) |=> (open_ptr == $past(seal_ptr)));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
      open_used <= PW'(DEPTH));

   p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (rst || flush)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind pkt_hold_fifo pkt_hold_fifo_chk #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .flush     (flush),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .in_err    (in_err),
   .out_data  (out_data),
   .out_last  (out_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .open_ptr  (open_ptr),
   .seal_ptr  (seal_ptr),
   .rd_ptr    (rd_ptr)
);

// File: tb/tb_pkt_hold_fifo.sv
`timescale 1ns/1ps
module tb_pkt_hold_fifo;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 32;
   localparam int DEPTH_LOG2 = 6;
   localparam int DEPTH      = 1 << DEPTH_LOG2;

   // Stimulus table: bit 8 = error on final word, bits 7:0 = packet length.
   localparam int NPKT = 8;
   localparam logic [8:0] PKTS [NPKT] = '{
      {1'b0, 8'd4}, {1'b0, 8'd1}, {1'b1, 8'd3}, {1'b0, 8'd6},
      {1'b0, 8'd2}, {1'b1, 8'd5}, {1'b0, 8'd1}, {1'b0, 8'd7}
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              flush = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              in_last = 1'b0;
   logic              in_err = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] out_data;
   logic              out_last;
   logic              out_valid;
   logic              out_ready = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [31:0] seq = 32'h100;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_hold_fifo #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) dut (
      .clk(clk), .rst(rst), .flush(flush),
      .in_data(in_data), .in_last(in_last), .in_err(in_err),
      .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_last(out_last),
      .out_valid(out_valid), .out_ready(out_ready)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Called at a negedge; returns at the negedge after the word is taken.
   task automatic push(input logic [31:0] d, input logic l, input logic e);
      bit ok;
      in_valid = 1'b1; in_data = d; in_last = l; in_err = e;
      forever begin
         ok = in_ready;
         @(negedge clk);
         if (ok) break;
      end
      in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
   endtask

   task automatic push_pkt(input int len, input logic err_last, output logic [31:0] first);
      first = seq;
      for (int i = 0; i < len; i++) begin
         push(seq, i == len-1, err_last && (i == len-1));
         seq++;
      end
   endtask

   task automatic pull_expect(input string req, input logic [31:0] ed, input logic el);
      logic [31:0] d;
      logic l;
      out_ready = 1'b1;
      forever begin
         if (out_valid) begin
            d = out_data; l = out_last;
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(d == ed, req, 64'(d), 64'(ed));
      chk(l == el, req, 64'(l), 64'(el));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin : main
      logic [31:0] a, b, c;
      int n_exp;
      logic [31:0] exp_d [$];
      logic        exp_l [$];

      idle(3);
      rst = 1'b0;
      @(negedge clk);

      // R1: reset state
      chk(!out_valid, "R1 reset out_valid", 64'(out_valid), 0);
      chk(in_ready,   "R1 reset in_ready", 64'(in_ready), 1);

      // R10 / R3 / R5: table walked with a concurrent reader under intermittent ready
      begin
         logic [31:0] s;
         s = seq;
         for (int p = 0; p < NPKT; p++) begin
            for (int i = 0; i < int'(PKTS[p][7:0]); i++) begin
               if (!PKTS[p][8]) begin
                  exp_d.push_back(s);
                  exp_l.push_back(i == int'(PKTS[p][7:0]) - 1);
               end
               s++;
            end
         end
         n_exp = exp_d.size();
      end
      fork
         begin
            for (int p = 0; p < NPKT; p++) begin
               push_pkt(int'(PKTS[p][7:0]), PKTS[p][8], a);
               idle(int'(PKTS[p][7:0]) % 2);
            end
         end
         begin
            int got = 0;
            int cyc = 0;
            while (got < n_exp) begin
               out_ready = (cyc % 3 != 2);
               if (out_ready && out_valid) begin
                  chk(out_data == exp_d[got], "R10 stream data", 64'(out_data), 64'(exp_d[got]));
                  chk(out_last == exp_l[got], "R3 stream last", 64'(out_last), 64'(exp_l[got]));
                  got++;
               end
               cyc++;
               @(negedge clk);
            end
            out_ready = 1'b0;
         end
      join
      idle(4);
      chk(!out_valid, "R5 dropped packets leave nothing", 64'(out_valid), 0);

      // R2: gating and latency of the first packet
      a = seq;
      for (int i = 0; i < 5; i++) begin push(seq, 1'b0, 1'b0); seq++; end
      idle(5);
      chk(!out_valid, "R2 partial hidden", 64'(out_valid), 0);
      push(seq, 1'b1, 1'b0); seq++;
      chk(!out_valid, "R2 not yet valid after final edge", 64'(out_valid), 0);
      @(negedge clk);
      chk(out_valid, "R2 valid one edge later", 64'(out_valid), 1);
      for (int i = 0; i < 6; i++) pull_expect("R2 data", a + 32'(i), i == 5);

      // R4: complete packet followed by partial packet
      push_pkt(3, 1'b0, a);
      b = seq;
      push(seq, 1'b0, 1'b0); seq++;
      push(seq, 1'b0, 1'b0); seq++;
      for (int i = 0; i < 3; i++) pull_expect("R4 complete packet", a + 32'(i), i == 2);
      idle(6);
      chk(!out_valid, "R4 partial not presented", 64'(out_valid), 0);
      push(seq, 1'b1, 1'b0); seq++;
      for (int i = 0; i < 3; i++) pull_expect("R4 partial after completion", b + 32'(i), i == 2);

      // R5 / R6: error on a body word is ignored, on the final word it drops the packet
      a = seq;
      push(seq, 1'b0, 1'b1); seq++;
      push(seq, 1'b1, 1'b0); seq++;
      push_pkt(4, 1'b1, b);
      push_pkt(2, 1'b0, c);
      pull_expect("R6 body error ignored", a, 1'b0);
      pull_expect("R6 body error ignored", a + 32'd1, 1'b1);
      pull_expect("R5 next packet after drop", c, 1'b0);
      pull_expect("R5 next packet after drop", c + 32'd1, 1'b1);
      idle(4);
      chk(!out_valid, "R5 nothing of dropped packet", 64'(out_valid), 0);

      // R7: exactly full packet
      a = seq;
      for (int i = 0; i < DEPTH; i++) begin
         if (!in_ready) chk(1'b0, "R7 ready during fill", 64'(i), DEPTH);
         push(seq, i == DEPTH-1, 1'b0); seq++;
      end
      chk(!in_ready, "R7 full after final word", 64'(in_ready), 0);
      for (int i = 0; i < DEPTH; i++) pull_expect("R7 full packet", a + 32'(i), i == DEPTH-1);

      // R9: output held under backpressure
      push_pkt(2, 1'b0, a);
      idle(2);
      chk(out_valid, "R9 valid present", 64'(out_valid), 1);
      b = out_data;
      idle(3);
      chk(out_valid && out_data == b && !out_last, "R9 held", 64'(out_data), 64'(a));
      pull_expect("R9 after stall", a, 1'b0);
      pull_expect("R9 after stall", a + 32'd1, 1'b1);

      // R8: overlong packet stalls, then flush (R1) clears it
      for (int i = 0; i < DEPTH; i++) begin push(seq, 1'b0, 1'b0); seq++; end
      chk(!in_ready, "R8 ready low at capacity", 64'(in_ready), 0);
      idle(10);
      chk(!in_ready, "R8 stays stalled", 64'(in_ready), 0);
      chk(!out_valid, "R8 nothing emitted", 64'(out_valid), 0);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      chk(in_ready,   "R1 flush frees input", 64'(in_ready), 1);
      chk(!out_valid, "R1 flush out_valid", 64'(out_valid), 0);
      push_pkt(2, 1'b0, a);
      pull_expect("R1 clean after flush", a, 1'b0);
      pull_expect("R1 clean after flush", a + 32'd1, 1'b1);

      // R1: flush while a word is presented
      push_pkt(3, 1'b0, a);
      idle(2);
      chk(out_valid, "R1 valid before flush", 64'(out_valid), 1);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      chk(!out_valid, "R1 flush drops presented word", 64'(out_valid), 0);
      idle(4);
      chk(!out_valid, "R1 remains empty", 64'(out_valid), 0);

      summary();
   end

endmodule